// File: doc/BRIEF.md
# ADC Power-State Sequencer

This controller sequences the power states of a sampling converter core. A 2-bit power-management field from a control register, together with a hardware stay-awake pin, selects one of four operating policies. The policies are: always powered, full power-down between conversions, partial power-down between conversions (the reference stays on), and permanent power-down. In the two between-conversion policies, one active-low convert strobe does two jobs. Its falling edge wakes the core, and its rising edge launches the conversion. When the core's busy signal later falls, the block drops back to the selected idle power state.

After reset the block waits for either the first strobe or a control-register write. The first falling strobe edge starts a power-on timeout followed by a self-calibration window, and the mode inputs are ignored during that window. A register write that arrives before that first strobe skips the whole window.

All durations are parameters in system-clock cycles. The strobe passes through a configurable synchroniser before edge detection.

Top module: `adc_pwr_seq`

## Requirements
- R1: With pm_field=00 and stay_up=1, the idle state keeps core_en, ref_en and ready high. A rising edge of the synchronised cnv_n produces a one-cycle conv_start, and a falling edge on its own has no effect.
- R2: With pm_field=01 at either stay_up level, or pm_field=00 with stay_up=0, the idle state has core_en=0, ref_en=0 and ready=0.
- R3: With pm_field=10, the idle state holds core_en=0 and ref_en=0. Strobe edges produce no conv_start and no change of power.
- R4: With pm_field=11, the idle state has core_en=0 and ref_en=1.
- R5: In a between-conversion mode, a falling strobe edge raises core_en and ref_en. ready rises after PWRUP_CYC cycles, and the next rising strobe edge gives one conv_start pulse.
- R6: A rising strobe edge that comes before the PWRUP_CYC count has expired sets early_err. early_err holds until the next accepted falling edge. The conversion is deferred, and conv_start is issued in the cycle after the count ends.
- R7: After conv_start, a high-to-low transition of busy returns the block to the idle power state of the current mode.
- R8: After reset, core_en=1, ref_en=1, ready=0 and cal_active=0. The first falling strobe edge raises cal_active for TMO_CYC+CAL_CYC cycles. During that window pm_field and stay_up have no effect and no conv_start is issued.
- R9: A cfg_wr pulse before the first falling strobe edge after reset cancels the timeout and calibration. cal_active never rises, and the block enters the idle state of the current mode.
- R10: cnv_n passes through SYNC_STAGES flip-flops and one edge register. A falling edge therefore changes the power outputs SYNC_STAGES+1 cycles after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_field | input | 2 | Power-management field from the control register |
| cfg_wr | input | 1 | One-cycle pulse marking a control-register write |
| stay_up | input | 1 | Hardware pin; high keeps the core awake when pm_field=00 |
| cnv_n | input | 1 | Active-low convert strobe |
| busy | input | 1 | High while the core is converting |
| core_en | output | 1 | Power enable for the converter core |
| ref_en | output | 1 | Power enable for the reference |
| conv_start | output | 1 | One-cycle conversion launch pulse |
| cal_active | output | 1 | High during the power-on timeout and calibration |
| ready | output | 1 | Core powered and waiting for a rising strobe edge |
| early_err | output | 1 | Rising strobe edge arrived during power-up |

## Verification
A wrong internal state shows at the power enables within the same cycle, because core_en, ref_en and ready are decoded from the state and the live mode inputs. A state that wakes too early or too late therefore appears as an enable mismatch on the first cycle it differs. Counter errors show as ready or cal_active moving one or more cycles away from the reference model's edge. A lost pending start shows as a missing conv_start and then a missing busy return. Every output is compared against the behavioural model on every clock, so any divergence is reported on the cycle it first appears.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
   typedef enum logic [2:0] {
      S_BOOT, S_TMO, S_CAL, S_REST, S_PWRUP, S_ARMED, S_CONV
   } seq_state_t;

   typedef enum logic [1:0] {
      M_ON, M_PD_FULL, M_PD_PART, M_OFF
   } pwr_mode_t;
endpackage

// File: rtl/adc_pwr_mode_dec.sv
module adc_pwr_mode_dec
   import adc_pwr_pkg::*;
(
   input  logic [1:0] field,
   input  logic       stay_up,
   output pwr_mode_t  mode
);
   always_comb begin
      case (field)
         2'b00:   mode = stay_up ? M_ON : M_PD_FULL;
         2'b01:   mode = M_PD_FULL;
         2'b10:   mode = M_OFF;
         default: mode = M_PD_PART;
      endcase
   end
endmodule

// File: rtl/adc_pwr_edge.sv
module adc_pwr_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic fall,
   output logic rise
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic chain [0:SYNC_STAGES];
   logic q;

   assign chain[0] = d;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i+1] <= 1'b1;
         else        chain[i+1] <= chain[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b1;
      else        q <= chain[SYNC_STAGES];
   end

   assign fall = q & ~chain[SYNC_STAGES];
   assign rise = ~q & chain[SYNC_STAGES];
endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   if (W < 1) begin : g_bad
      $error("timer width must be positive");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R5 / R8: an idle counter only moves when reloaded
   a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero);
   // R6: a running counter steps down by exactly one
   a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
   import adc_pwr_pkg::*;
#(
   parameter int PWRUP_CYC   = 1000,
   parameter int TMO_CYC     = 4000000,
   parameter int CAL_CYC     = 10000000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pm_field,
   input  logic       cfg_wr,
   input  logic       stay_up,
   input  logic       cnv_n,
   input  logic       busy,
   output logic       core_en,
   output logic       ref_en,
   output logic       conv_start,
   output logic       cal_active,
   output logic       ready,
   output logic       early_err
);
   localparam int MAX_AB = (PWRUP_CYC > TMO_CYC) ? PWRUP_CYC : TMO_CYC;
   localparam int MAXC   = (MAX_AB > CAL_CYC) ? MAX_AB : CAL_CYC;
   localparam int CW     = $clog2(MAXC + 1);
   localparam logic [CW-1:0] PU_V  = CW'(PWRUP_CYC - 1);
   localparam logic [CW-1:0] TMO_V = CW'(TMO_CYC - 1);
   localparam logic [CW-1:0] CAL_V = CW'(CAL_CYC - 1);

   if (PWRUP_CYC < 1 || TMO_CYC < 1 || CAL_CYC < 1) begin : g_bad
      $error("all cycle counts must be at least 1");
   end

   seq_state_t   st, st_n;
   pwr_mode_t    mode;
   logic         fall, rise, zero, ld;
   logic [CW-1:0] ld_v;
   logic         busy_q, pend, pend_n, err_n, cv_n;

   adc_pwr_mode_dec u_dec (.field(pm_field), .stay_up(stay_up), .mode(mode));

   adc_pwr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .d(cnv_n), .fall(fall), .rise(rise));

   adc_pwr_timer #(.W(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_v), .zero(zero));

   always_comb begin
      st_n   = st;
      ld     = 1'b0;
      ld_v   = '0;
      cv_n   = 1'b0;
      pend_n = pend;
      err_n  = early_err;
      case (st)
         S_BOOT:
            if (cfg_wr) st_n = S_REST;
            else if (fall) begin
               st_n = S_TMO; ld = 1'b1; ld_v = TMO_V;
            end
         S_TMO:
            if (zero) begin
               st_n = S_CAL; ld = 1'b1; ld_v = CAL_V;
            end
         S_CAL:
            if (zero) st_n = S_REST;
         S_REST:
            case (mode)
               M_ON:  if (rise) begin st_n = S_CONV; cv_n = 1'b1; end
               M_OFF: st_n = S_REST;
               default:
                  if (fall) begin
                     st_n = S_PWRUP; ld = 1'b1; ld_v = PU_V;
                     err_n = 1'b0; pend_n = 1'b0;
                  end
            endcase
         S_PWRUP:
            if (zero) begin
               if (pend || rise) begin
                  st_n = S_CONV; cv_n = 1'b1; pend_n = 1'b0;
               end else begin
                  st_n = S_ARMED;
               end
            end else if (rise) begin
               pend_n = 1'b1; err_n = 1'b1;
            end
         S_ARMED:
            if (rise) begin st_n = S_CONV; cv_n = 1'b1; end
         S_CONV:
            if (busy_q && !busy) st_n = S_REST;
         default: st_n = S_BOOT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_BOOT;
         busy_q     <= 1'b0;
         pend       <= 1'b0;
         early_err  <= 1'b0;
         conv_start <= 1'b0;
      end else begin
         st         <= st_n;
         busy_q     <= busy;
         pend       <= pend_n;
         early_err  <= err_n;
         conv_start <= cv_n;
      end
   end

   always_comb begin
      core_en    = (st != S_REST) || (mode == M_ON);
      ref_en     = core_en || (st == S_REST && mode == M_PD_PART);
      ready      = (st == S_ARMED) || (st == S_REST && mode == M_ON);
      cal_active = (st == S_TMO) || (st == S_CAL);
   end

   // R5: a launch pulse lasts one cycle and only happens while powered
   a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   a_r5_start_powered: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (core_en && ref_en));
   // R1: ready implies both supplies on
   a_r1_ready_powered: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (core_en && ref_en));
   // R3: the off mode swallows strobe edges
   a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_REST && mode == M_OFF) |=> !conv_start);
   // R6: the early flag only rises out of the power-up phase
   a_r6_early_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(early_err) |-> ($past(st) == S_PWRUP));
   // R7: a busy fall during conversion returns to idle
   a_r7_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CONV && busy_q && !busy) |=> (st == S_REST));
   // R8: no conversion launches inside the calibration window
   a_r8_cal_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      cal_active |-> !conv_start);
   // R9: a register write at boot skips calibration
   a_r9_skip_cal: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BOOT && cfg_wr) |=> !cal_active);
endmodule

// File: tb/adc_pwr_seq_test.sv
`timescale 1ns/100ps
module adc_pwr_seq_test;
   localparam int PU   = 8;
   localparam int TMO  = 20;
   localparam int CAL  = 30;
   localparam int SYNC = 2;
   localparam int CONV_LEN = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] pm_field = 2'b00;
   logic cfg_wr = 1'b0, stay_up = 1'b0, cnv_n = 1'b1, busy = 1'b0;
   logic core_en, ref_en, conv_start, cal_active, ready, early_err;

   int n_cmp = 0, n_bad = 0;
   string cur_req = "R8";
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   adc_pwr_seq #(.PWRUP_CYC(PU), .TMO_CYC(TMO), .CAL_CYC(CAL),
                 .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .pm_field(pm_field), .cfg_wr(cfg_wr),
      .stay_up(stay_up), .cnv_n(cnv_n), .busy(busy), .core_en(core_en),
      .ref_en(ref_en), .conv_start(conv_start), .cal_active(cal_active),
      .ready(ready), .early_err(early_err));

   // behavioural reference: phase 0 boot,1 timeout,2 cal,3 idle,4 wake,5 armed,6 converting
   int  ph = 0, left = 0;
   bit  pend = 0, err = 0, cq = 1, bq = 0, cvs = 0, chk_en = 0;
   bit  sh [0:SYNC-1];

   function automatic int mode_of(logic [1:0] f, logic s);
      if (f == 2'b00) return s ? 0 : 1;
      if (f == 2'b01) return 1;
      if (f == 2'b10) return 3;
      return 2;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; left = 0; pend = 0; err = 0; cq = 1; bq = 0; cvs = 0;
         chk_en = 0;
         foreach (sh[i]) sh[i] = 1'b1;
      end else begin
         bit cs, fl, rs, ld;
         int md, nl, nph;
         cs = sh[SYNC-1];
         fl = cq && !cs;
         rs = !cq && cs;
         md = mode_of(pm_field, stay_up);
         nph = ph; ld = 0; nl = 0; cvs = 0;
         if (ph == 0) begin
            if (cfg_wr) nph = 3;
            else if (fl) begin nph = 1; ld = 1; nl = TMO - 1; end
         end else if (ph == 1) begin
            if (left == 0) begin nph = 2; ld = 1; nl = CAL - 1; end
         end else if (ph == 2) begin
            if (left == 0) nph = 3;
         end else if (ph == 3) begin
            if (md == 0 && rs) begin nph = 6; cvs = 1; end
            else if ((md == 1 || md == 2) && fl) begin
               nph = 4; ld = 1; nl = PU - 1; err = 0; pend = 0;
            end
         end else if (ph == 4) begin
            if (left == 0) begin
               if (pend || rs) begin nph = 6; cvs = 1; pend = 0; end
               else nph = 5;
            end else if (rs) begin pend = 1; err = 1; end
         end else if (ph == 5) begin
            if (rs) begin nph = 6; cvs = 1; end
         end else begin
            if (bq && !busy) nph = 3;
         end
         if (ld) left = nl;
         else if (left > 0) left = left - 1;
         ph = nph;
         cq = cs;
         for (int i = SYNC - 1; i > 0; i--) sh[i] = sh[i-1];
         sh[0] = cnv_n;
         bq = busy;
         chk_en = 1;
      end
   end

   task automatic check1(string nm, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (chk_en && rst_n && !done) begin
         int md;
         bit m_core;
         md = mode_of(pm_field, stay_up);
         m_core = (ph != 3) || (md == 0);
         check1("core_en", core_en, m_core);
         check1("ref_en", ref_en, m_core || (ph == 3 && md == 2));
         check1("ready", ready, (ph == 5) || (ph == 3 && md == 0));
         check1("cal_active", cal_active, (ph == 1 || ph == 2));
         check1("conv_start", conv_start, cvs);
         check1("early_err", early_err, err);
      end
   end

   // stub core: busy for CONV_LEN cycles after each launch
   int bcnt = 0;
   always @(negedge clk) begin
      if (!rst_n) bcnt = 0;
      else if (bcnt > 0) bcnt--;
      else if (conv_start) bcnt = CONV_LEN;
      busy = (bcnt > 0);
   end

   task automatic strobe(int low, int gap);
      @(negedge clk) cnv_n = 1'b0;
      repeat (low) @(negedge clk);
      cnv_n = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      cur_req = "R8";
      check1("rst core_en", core_en, 1'b1);
      check1("rst ref_en", ref_en, 1'b1);
      check1("rst ready", ready, 1'b0);
      check1("rst cal_active", cal_active, 1'b0);
      check1("rst conv_start", conv_start, 1'b0);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      do_reset();
      cur_req = "R8";
      strobe(12, 4);
      stay_up = 1'b1; pm_field = 2'b10;
      repeat (10) @(negedge clk);
      stay_up = 1'b0; pm_field = 2'b00;
      repeat (50) @(negedge clk);
      cur_req = "R5"; strobe(12, 20);
      cur_req = "R6"; strobe(3, 30);
      cur_req = "R10"; strobe(1, 25);
      cur_req = "R4"; pm_field = 2'b11; repeat (4) @(negedge clk); strobe(12, 20);
      cur_req = "R7"; strobe(14, 25);
      cur_req = "R1"; pm_field = 2'b00; stay_up = 1'b1;
      repeat (4) @(negedge clk);
      strobe(2, 20); strobe(5, 20);
      cur_req = "R3"; pm_field = 2'b10; stay_up = 1'b0; strobe(12, 20);
      cur_req = "R2"; pm_field = 2'b01; stay_up = 1'b1; strobe(12, 20);
      stay_up = 1'b0; strobe(12, 20);
      do_reset();
      cur_req = "R9";
      @(negedge clk) cfg_wr = 1'b1;
      @(negedge clk) cfg_wr = 1'b0;
      repeat (3) @(negedge clk);
      strobe(12, 25);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
         finish_run();
      end
   end
endmodule